// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital control side of a single-channel successive-approximation analog-to-digital converter. A conversion starts when software pulses a start strobe. It can also start on a falling edge of an active-low external trigger pin, provided the trigger enable is set. Once started, the sequencer waits for the next boundary of a free-running clock divider and a fixed lead-in. It then opens the input sample window and runs ten successive-approximation bit decisions against a comparator input. At the end it publishes the result and a completion flag.

The completion flag drives a gated interrupt request. Software clears the flag with a read-then-write-zero sequence. A DMA access to the converter clears it directly. One clock-select input picks between a slow timing set (divider 8, 64-cycle sample window) and a fast set (divider 4, 32-cycle window). The analog side is reduced to a trial code output and a one-bit comparator answer.

Top module: `adc_conv_seq`

## Requirements
- R1: During and right after synchronous reset: `busy`, `sampling`, `done` and `irq` are 0, and `dac_code` and `result` are 0.
- R2: Let P be the divider ratio: 8 when `clk_sel` is 0 at start, 4 when it is 1. Clock edges are numbered from reset release, and the first edge with `rst` low is edge 0. The start delay D is the number of edges from the edge that captures the start to the edge that raises `sampling`. D equals P+1+k. Here k (1..P) counts edges from the start edge up to the first edge whose number modulo P is P-1. D therefore spans 10..17 (slow) or 6..9 (fast), and each of those values occurs for some start phase. `busy` is 1 from the edge that captures the start.
- R3: `sampling` stays high for exactly 64 cycles (slow) or 32 cycles (fast).
- R4: From the start edge to the edge that sets `done`, the time is D+64+185 in slow mode (259..266) and D+32+93 in fast mode (131..134).
- R5: Ten bit decisions are made MSB first. `cmp_in`=1 keeps the trial bit shown on `dac_code` and 0 drops it. When `cmp_in` is 1 exactly when `dac_code` is less than or equal to an input code, `result` equals that code.
- R6: `clk_sel` is captured when a conversion starts. Changing it during the conversion does not alter that conversion's timing.
- R7: A start request while `busy` is 1 is ignored: the timing is unchanged and no second conversion follows.
- R8: With `trig_en`=1, a high-to-low transition of `ext_trig_n` starts a conversion. `busy` rises on the third clock edge after the pin goes low. A pin held low starts only one conversion. With `trig_en`=0 the pin has no effect.
- R9: On the edge that ends a conversion, `done` becomes 1, `result` takes the new code and `busy` returns to 0.
- R10: `irq` is `done` AND `irq_en`. A change of `irq_en` appears on `irq` one cycle later.
- R11: `flag_wr0` clears `done` only if `flag_rd` was pulsed while `done` was 1 in an earlier cycle. A `flag_wr0` without a prior read leaves `done` at 1.
- R12: A `dma_acc` pulse clears `done`, and with it `irq`, on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software start strobe |
| clk_sel | input | 1 | Timing select: 0 slow, 1 fast |
| trig_en | input | 1 | Enables the external trigger pin |
| ext_trig_n | input | 1 | Asynchronous active-low trigger pin |
| irq_en | input | 1 | Interrupt request enable |
| flag_rd | input | 1 | Software read of the completion flag |
| flag_wr0 | input | 1 | Software write of 0 to the completion flag |
| dma_acc | input | 1 | DMA access to a converter register |
| cmp_in | input | 1 | Comparator answer for the current trial code |
| busy | output | 1 | Conversion in progress (start bit) |
| sampling | output | 1 | Input sample window open |
| dac_code | output | 10 | Trial code for the DAC |
| result | output | 10 | Last conversion result |
| done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong divider phase or a wrong lead count shows on the next start as a sampling edge that comes early or late by whole cycles. That error is visible within 17 cycles of `busy` rising. A miscounted window or bit period moves the `done` edge, so the error appears within one conversion of at most 266 cycles. A wrong keep-or-drop decision leaves a wrong `result` at that same edge. Flag and gating errors show on `done` or `irq` one cycle after the offending strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_LEAD,
    ST_SAMPLE,
    ST_CONV,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain[STAGES-1];
  end

  assign fall = last_q & ~chain[STAGES-1];

  // a synchronized falling edge yields a single-cycle request
  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int DIV_SLOW = 8,
  parameter int DIV_FAST = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_fast,
  output logic tick
);
  localparam int PW = $clog2(DIV_SLOW);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + PW'(1);
  end

  assign mask = sel_fast ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  assign tick = (pre_q & mask) == mask;

  // boundaries are never back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int NBITS    = 10,
  parameter int DIV_SLOW = 8,
  parameter int DIV_FAST = 4,
  parameter int SMP_SLOW = 64,
  parameter int SMP_FAST = 32,
  parameter int CNV_SLOW = 185,
  parameter int CNV_FAST = 93
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             clk_sel,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             mode_fast,
  output logic             busy,
  output logic             sampling,
  output logic             finish,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] result
);
  localparam int CW     = $clog2(SMP_SLOW + SMP_FAST + CNV_SLOW + CNV_FAST + DIV_SLOW + DIV_FAST + 4);
  localparam int BW     = $clog2(NBITS);
  localparam int BIT_S  = CNV_SLOW / NBITS;
  localparam int BIT_F  = CNV_FAST / NBITS;
  localparam int TAIL_S = CNV_SLOW - NBITS * BIT_S;
  localparam int TAIL_F = CNV_FAST - NBITS * BIT_F;

  seq_state_e       st;
  logic             mode_q;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [NBITS-1:0] code_q;
  logic [NBITS-1:0] res_q;

  logic [CW-1:0]    lead_len, smp_len, bit_len, tail_len;
  logic [NBITS-1:0] bit_oh;
  logic [NBITS-1:0] kept;
  logic             last_bit;

  assign lead_len = mode_q ? CW'(DIV_FAST + 1) : CW'(DIV_SLOW + 1);
  assign smp_len  = mode_q ? CW'(SMP_FAST)     : CW'(SMP_SLOW);
  assign bit_len  = mode_q ? CW'(BIT_F)        : CW'(BIT_S);
  assign tail_len = mode_q ? CW'(TAIL_F)       : CW'(TAIL_S);

  assign bit_oh   = {{(NBITS-1){1'b0}}, 1'b1} << bidx;
  assign kept     = cmp_in ? code_q : (code_q & ~bit_oh);
  assign last_bit = (st == ST_CONV) && (cnt == '0) && (bidx == '0);

  assign finish = (last_bit && (tail_len == '0)) ||
                  ((st == ST_TAIL) && (cnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      mode_q <= 1'b0;
      cnt    <= '0;
      bidx   <= '0;
      code_q <= '0;
      res_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_req) begin
            st     <= ST_ALIGN;
            mode_q <= clk_sel;
          end
        end
        ST_ALIGN: begin
          if (tick) begin
            st  <= ST_LEAD;
            cnt <= lead_len - CW'(1);
          end
        end
        ST_LEAD: begin
          if (cnt == '0) begin
            st  <= ST_SAMPLE;
            cnt <= smp_len - CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_SAMPLE: begin
          if (cnt == '0) begin
            st     <= ST_CONV;
            cnt    <= bit_len - CW'(1);
            bidx   <= BW'(NBITS - 1);
            code_q <= {1'b1, {(NBITS-1){1'b0}}};
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_CONV: begin
          if (cnt == '0) begin
            if (bidx == '0) begin
              if (tail_len == '0) begin
                st     <= ST_IDLE;
                res_q  <= kept;
                code_q <= '0;
              end else begin
                st     <= ST_TAIL;
                cnt    <= tail_len - CW'(1);
                code_q <= kept;
              end
            end else begin
              bidx   <= bidx - BW'(1);
              cnt    <= bit_len - CW'(1);
              code_q <= kept | (bit_oh >> 1);
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_TAIL: begin
          if (cnt == '0) begin
            st     <= ST_IDLE;
            res_q  <= code_q;
            code_q <= '0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mode_fast = mode_q;
  assign busy      = (st != ST_IDLE);
  assign sampling  = (st == ST_SAMPLE);
  assign dac_code  = code_q;
  assign result    = res_q;

  // window length monitor
  logic [CW-1:0] smp_run;
  always_ff @(posedge clk) begin
    if (rst)                  smp_run <= '0;
    else if (st == ST_SAMPLE) smp_run <= smp_run + CW'(1);
    else                      smp_run <= '0;
  end

  assert_sample_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(st == ST_SAMPLE) |-> smp_run == smp_len);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> busy);

  assert_mode_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_q));
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic rd,
  input  logic wr0,
  input  logic dma,
  input  logic irq_en,
  output logic done,
  output logic irq
);
  logic armed;
  logic clr;
  logic done_n;

  assign clr    = dma | (wr0 & armed);
  assign done_n = set ? 1'b1 : (clr ? 1'b0 : done);

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      irq   <= 1'b0;
      armed <= 1'b0;
    end else begin
      done <= done_n;
      irq  <= done_n & irq_en;
      if (clr)              armed <= 1'b0;
      else if (rd && done)  armed <= 1'b1;
    end
  end

  assert_done_set_R9: assert property (@(posedge clk) disable iff (rst)
    set |=> done);

  assert_dma_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (dma && !set) |=> !done);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  assert_blind_write_R11: assert property (@(posedge clk) disable iff (rst)
    (wr0 && !dma && !armed && done) |=> done);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int NBITS       = 10,
  parameter int DIV_SLOW    = 8,
  parameter int DIV_FAST    = 4,
  parameter int SMP_SLOW    = 64,
  parameter int SMP_FAST    = 32,
  parameter int CNV_SLOW    = 185,
  parameter int CNV_FAST    = 93,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_start,
  input  logic             clk_sel,
  input  logic             trig_en,
  input  logic             ext_trig_n,
  input  logic             irq_en,
  input  logic             flag_rd,
  input  logic             flag_wr0,
  input  logic             dma_acc,
  input  logic             cmp_in,
  output logic             busy,
  output logic             sampling,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] result,
  output logic             done,
  output logic             irq
);
  logic trig_fall;
  logic tick;
  logic mode_fast;
  logic finish;
  logic start_req;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (ext_trig_n),
    .fall  (trig_fall)
  );

  adc_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .sel_fast (mode_fast),
    .tick     (tick)
  );

  assign start_req = sw_start | (trig_en & trig_fall);

  adc_seq_core #(
    .NBITS(NBITS), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
    .SMP_SLOW(SMP_SLOW), .SMP_FAST(SMP_FAST),
    .CNV_SLOW(CNV_SLOW), .CNV_FAST(CNV_FAST)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .clk_sel   (clk_sel),
    .tick      (tick),
    .cmp_in    (cmp_in),
    .mode_fast (mode_fast),
    .busy      (busy),
    .sampling  (sampling),
    .finish    (finish),
    .dac_code  (dac_code),
    .result    (result)
  );

  adc_flag_ctrl u_flag (
    .clk    (clk),
    .rst    (rst),
    .set    (finish),
    .rd     (flag_rd),
    .wr0    (flag_wr0),
    .dma    (dma_acc),
    .irq_en (irq_en),
    .done   (done),
    .irq    (irq)
  );

  assert_end_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_trig_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !sw_start && !trig_en) |=> !busy);
endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_start = 1'b0, clk_sel = 1'b0, trig_en = 1'b0, ext_trig_n = 1'b1;
  logic       irq_en = 1'b0, flag_rd = 1'b0, flag_wr0 = 1'b0, dma_acc = 1'b0;
  logic       cmp_in;
  logic       busy, sampling, done, irq;
  logic [9:0] dac_code, result;
  int         vin = 0;
  int         ecnt = 0;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  assign cmp_in = (int'(dac_code) <= vin);

  adc_conv_seq u_adc_conv_seq (
    .clk(clk), .rst(rst), .sw_start(sw_start), .clk_sel(clk_sel),
    .trig_en(trig_en), .ext_trig_n(ext_trig_n), .irq_en(irq_en),
    .flag_rd(flag_rd), .flag_wr0(flag_wr0), .dma_acc(dma_acc), .cmp_in(cmp_in),
    .busy(busy), .sampling(sampling), .dac_code(dac_code), .result(result),
    .done(done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One conversion. act: 0 none, 1 flip clk_sel mid-run, 2 extra start mid-run.
  task automatic conv(input logic cks, input int v, input bit trig, input int act,
                      input int align_p, input int align_j, output int d_out);
    int e0, p, k, dexp, s_exp, c_exp, waits, idx, d, s, t;
    vin = v;
    clk_sel = cks;
    @(negedge clk); dma_acc = 1'b1;
    @(negedge clk); dma_acc = 1'b0;
    if (align_p > 0) while ((ecnt % align_p) != align_j) @(negedge clk);
    if (trig) begin ext_trig_n = 1'b0; e0 = ecnt + 2; end
    else      begin sw_start = 1'b1;   e0 = ecnt;     end
    @(negedge clk);
    sw_start = 1'b0;
    waits = 1;
    while (!busy && waits < 20) begin @(negedge clk); waits++; end
    if (trig) chk(waits == 3, "R8 trigger latency", waits, 3);
    else      chk(waits == 1, "R2 busy after start", waits, 1);
    p     = cks ? 4 : 8;
    s_exp = cks ? 32 : 64;
    c_exp = cks ? 93 : 185;
    k = 1;
    while (((e0 + k) % p) != p - 1) k++;
    dexp = p + 1 + k;
    idx = 0; d = -1; s = 0; t = -1;
    while (t < 0 && idx < 400) begin
      if (sampling) begin if (d < 0) d = idx; s++; end
      if (done) begin
        t = idx;
        chk(busy == 1'b0, "R9 busy clear at done", busy, 0);
        chk(int'(result) == v, "R5 result code", result, v);
        chk(irq == irq_en, "R10 irq at done", irq, irq_en);
      end
      if (idx == 5 && act == 1) clk_sel = ~cks;
      if (idx == 5 && act == 2) sw_start = 1'b1;
      if (idx == 6 && act == 2) sw_start = 1'b0;
      @(negedge clk);
      idx++;
    end
    chk(d == dexp, "R2 start delay", d, dexp);
    chk(d >= p + 2 && d <= 2 * p + 1, "R2 delay range", d, p + 2);
    chk(s == s_exp, "R3 sample window", s, s_exp);
    chk(t == dexp + s_exp + c_exp, "R4 total time", t, dexp + s_exp + c_exp);
    clk_sel = cks;
    d_out = d;
  endtask

  initial begin
    int d, v, p;
    logic [31:0] seen;
    bit quiet;
    repeat (3) @(negedge clk);
    chk(!busy && !sampling && !done && !irq, "R1 in reset flags", {busy, sampling, done, irq}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !sampling && !done && !irq, "R1 after reset flags", {busy, sampling, done, irq}, 0);
    chk(dac_code == 10'd0 && result == 10'd0, "R1 codes", int'(dac_code) + int'(result), 0);

    // phase sweeps in both timing sets
    for (int m = 0; m < 2; m++) begin
      p = (m == 0) ? 8 : 4;
      seen = '0;
      for (int j = 0; j < p; j++) begin
        v = (j == 0) ? 0 : ((j == p - 1) ? 1023 : (j * 293 + 17) % 1024);
        irq_en = j[0];
        conv(m[0], v, 1'b0, 0, p, j, d);
        if (d >= p + 2 && d <= 2 * p + 1) seen[d - (p + 2)] = 1'b1;
      end
      chk(seen == (32'd1 << p) - 32'd1, "R2 all delay phases", seen, (1 << p) - 1);
    end

    // R6: select change mid-conversion ignored
    conv(1'b0, 512, 1'b0, 1, 0, 0, d);
    conv(1'b1, 511, 1'b0, 1, 0, 0, d);

    // R7: start while busy ignored, no follow-on conversion
    conv(1'b0, 341, 1'b0, 2, 0, 0, d);
    quiet = 1'b1;
    repeat (20) begin if (busy) quiet = 1'b0; @(negedge clk); end
    chk(quiet, "R7 no second conversion", !quiet, 0);

    // R8: trigger start, held low gives one conversion
    trig_en = 1'b1;
    conv(1'b1, 682, 1'b1, 0, 0, 0, d);
    quiet = 1'b1;
    repeat (60) begin if (busy) quiet = 1'b0; @(negedge clk); end
    chk(quiet, "R8 held low single start", !quiet, 0);
    ext_trig_n = 1'b1;
    repeat (5) @(negedge clk);
    trig_en = 1'b0;
    ext_trig_n = 1'b0;
    quiet = 1'b1;
    repeat (20) begin if (busy) quiet = 1'b0; @(negedge clk); end
    chk(quiet, "R8 trigger disabled", !quiet, 0);
    ext_trig_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 / R11 flag and interrupt gating
    irq_en = 1'b1;
    conv(1'b1, 1, 1'b0, 0, 0, 0, d);
    chk(done && irq, "R10 irq with enable", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk(!irq && done, "R10 irq gated off", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq, "R10 irq regated on", irq, 1);
    flag_wr0 = 1'b1;
    @(negedge clk);
    flag_wr0 = 1'b0;
    chk(done, "R11 blind write ignored", done, 1);
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    flag_wr0 = 1'b1;
    @(negedge clk);
    flag_wr0 = 1'b0;
    chk(!done && !irq, "R11 read then write clears", done, 0);

    // R12 DMA clear
    conv(1'b1, 1022, 1'b0, 0, 0, 0, d);
    chk(done && irq, "R12 flag before dma", done, 1);
    dma_acc = 1'b1;
    @(negedge clk);
    dma_acc = 1'b0;
    chk(!done && !irq, "R12 dma clears flag", done, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule